// File: doc/BRIEF.md
# Priority Interrupt Sequencer with Traps

This block decides when a small two-state processor leaves normal execution for its interrupt state. Four request sources feed it: an illegal-operation trap, an I/O completion request that carries a trunk number, a device number and a status byte, an elapsed-timer overflow, and an arithmetic overflow or divide exception. Each request is latched as pending. When the processor is running normally, the highest-priority pending request that the mask byte allows is taken.

Taking a request starts a short save sequence on a byte write port, one write per cycle. The first write stores the current condition code. An I/O request adds two more writes: its trunk/device identity and its status byte. When the sequence ends, the block tells the core to load a condition code of zero, and it switches fetch to the interrupt-state counter. A return strobe issued in the interrupt state does three things: it reloads the saved condition code, clears the active interrupt, and hands fetch back to the normal counter.

Top module: `int_seq_top`

## Requirements
- R1: After reset the block is in the processing state. It makes no write, `busy`, `intr_mode` and `cc_load` are low, and nothing is pending.
- R2: Each request pulse sets a pending flag. The flag stays set until its source is taken, including while its mask bit is 0. A request is never taken in the same cycle in which it arrives.
- R3: Among requests that are both pending and enabled, the fixed priority is: trap first, then I/O, then timer, then arithmetic exception. `cause` reports the taken source as 0 for trap, 1 for I/O, 2 for timer and 3 for arithmetic.
- R4: Mask bit 0 enables I/O, bit 1 enables the timer and bit 2 enables the arithmetic exception. The trap ignores the mask. A request whose mask bit is 0 is not taken.
- R5: Taking a source starts the save sequence in the next cycle, with one write per cycle while `busy` is high. The first write goes to address 43 with data equal to the condition code captured when the source was taken, zero-extended. For I/O only, two more writes follow: address 47 with data {0, trunk[2:0], device[3:0]}, then address 48 with the status byte.
- R6: In the cycle after the last save write, `busy` falls and `intr_mode` rises. In that same cycle `cc_load` pulses for one cycle with `cc_val` = 0.
- R7: While `intr_mode` is high, no request is taken and no write is made. Requests that are still pending remain pending.
- R8: A return strobe in the interrupt state clears `intr_mode` in the next cycle. In that cycle `cc_load` pulses with `cc_val` equal to the saved condition code, and the next pending enabled request may be taken one cycle later. A return strobe in the processing state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_trap | input | 1 | Illegal-operation trap request pulse |
| io_done | input | 1 | I/O completion request pulse |
| io_trunk | input | TRUNK_W | Trunk number, captured with `io_done` |
| io_dev | input | DEV_W | Device number, captured with `io_done` |
| io_status | input | 8 | Device status byte, captured with `io_done` |
| timer_ovf | input | 1 | Elapsed-timer overflow request pulse |
| arith_exc | input | 1 | Arithmetic overflow / divide exception request pulse |
| mask_byte | input | 8 | Enable mask (bit 0 I/O, bit 1 timer, bit 2 arithmetic) |
| cc_cur | input | CC_W | Current condition code of the core |
| ret_cmd | input | 1 | Return-from-interrupt strobe |
| wr_en | output | 1 | Save-write enable |
| wr_addr | output | ADDR_W | Save-write byte address |
| wr_data | output | 8 | Save-write data byte |
| busy | output | 1 | Save sequence in progress |
| intr_mode | output | 1 | High selects the interrupt-state counter for fetch |
| cause | output | 2 | Source being serviced |
| cc_load | output | 1 | One-cycle strobe: core loads `cc_val` into its condition code |
| cc_val | output | CC_W | Condition code value for the core to load |

## Verification
The bench uses the default parameters: a 16-bit address, a 3-bit trunk, a 4-bit device and a 2-bit condition code. With only four sources and three mask bits, every combination of simultaneous requests (16 sets) can be swept against every mask setting (8 values). For each of the 128 cases, the bench checks the first source taken, the full save sequence, the condition-code handling and the return. It then opens the mask fully and drains the remaining requests in priority order. Masked requests surviving until the mask opens, requests still pending during an interrupt, and the varying length of the I/O save sequence are all exercised by this sweep.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;

    localparam int NSRC = 4;

    // Source index doubles as priority rank: lower index wins.
    typedef enum logic [1:0] {
        SRC_TRAP  = 2'd0,
        SRC_IO    = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_ARITH = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SAVE = 2'd1,
        ST_INTR = 2'd2
    } st_e;

    // Captured I/O completion information.
    typedef struct packed {
        logic [7:0] id;
        logic [7:0] stat;
    } io_info_s;

    // Mask bit guarding a source; -1 means the source cannot be masked.
    function automatic int mask_pos(int k);
        case (k)
            1:       return 0;
            2:       return 1;
            3:       return 2;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/int_pend.sv
module int_pend
    import int_seq_pkg::*;
#(
    parameter int TRUNK_W = 3,
    parameter int DEV_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    req,
    input  logic [NSRC-1:0]    clr,
    input  logic [TRUNK_W-1:0] io_trunk,
    input  logic [DEV_W-1:0]   io_dev,
    input  logic [7:0]         io_status,
    output logic [NSRC-1:0]    pend,
    output io_info_s           io_info
);
    localparam int ID_W = TRUNK_W + DEV_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            io_info <= '0;
        end else begin
            pend <= (pend & ~clr) | req;
            if (req[SRC_IO]) begin
                io_info.id   <= 8'({io_trunk, io_dev});
                io_info.stat <= io_status;
            end
        end
    end

    // R2: a pending flag is only dropped when its source is taken
    for (genvar k = 0; k < NSRC; k++) begin : g_hold
        a_r2_pend_kept: assert property (@(posedge clk) disable iff (rst)
            (pend[k] && !clr[k]) |=> pend[k]);
    end

    initial begin
        if (ID_W > 8) $error("trunk and device do not fit one byte");
    end

endmodule

// File: rtl/int_arb.sv
module int_arb
    import int_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic [7:0]      mask_byte,
    input  logic            open,
    output logic            gnt_valid,
    output src_e            gnt_src,
    output logic [NSRC-1:0] gnt_vec
);
    logic [NSRC-1:0] en;

    for (genvar k = 0; k < NSRC; k++) begin : g_en
        if (mask_pos(k) < 0) begin : g_fixed
            assign en[k] = pend[k];
        end else begin : g_masked
            assign en[k] = pend[k] & mask_byte[mask_pos(k)];
        end
    end

    always_comb begin
        gnt_valid = 1'b0;
        gnt_src   = SRC_TRAP;
        gnt_vec   = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (en[k]) begin
                gnt_valid = open;
                gnt_src   = src_e'(k);
            end
        end
        if (gnt_valid) gnt_vec[gnt_src] = 1'b1;
    end

    // R3: at most one source granted per cycle
    a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_vec));
    // R4: an open pending trap always wins, whatever the mask
    a_r4_trap_unmasked: assert property (@(posedge clk) disable iff (rst)
        (open && pend[SRC_TRAP]) |-> (gnt_valid && gnt_src == SRC_TRAP));

endmodule

// File: rtl/int_fsm.sv
module int_fsm
    import int_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CC_W     = 2,
    parameter int CC_LOC   = 43,
    parameter int ID_LOC   = 47,
    parameter int STAT_LOC = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt_valid,
    input  src_e              gnt_src,
    input  io_info_s          io_info,
    input  logic [CC_W-1:0]   cc_cur,
    input  logic              ret_cmd,
    output logic              open,
    output logic              take,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              intr_mode,
    output src_e              cause,
    output logic              cc_load,
    output logic [CC_W-1:0]   cc_val
);
    st_e             st;
    logic [1:0]      step;
    src_e            src;
    logic [CC_W-1:0] saved_cc;
    io_info_s        info_q;
    logic            last;

    assign open      = (st == ST_RUN);
    assign take      = open && gnt_valid;
    assign last      = (src != SRC_IO) || (step == 2'd2);
    assign busy      = (st == ST_SAVE);
    assign intr_mode = (st == ST_INTR);
    assign cause     = src;
    assign wr_en     = busy;

    always_comb begin
        case (step)
            2'd0: begin
                wr_addr = ADDR_W'(CC_LOC);
                wr_data = 8'(saved_cc);
            end
            2'd1: begin
                wr_addr = ADDR_W'(ID_LOC);
                wr_data = info_q.id;
            end
            default: begin
                wr_addr = ADDR_W'(STAT_LOC);
                wr_data = info_q.stat;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_RUN;
            step     <= '0;
            src      <= SRC_TRAP;
            saved_cc <= '0;
            info_q   <= '0;
            cc_load  <= 1'b0;
            cc_val   <= '0;
        end else begin
            cc_load <= 1'b0;
            case (st)
                ST_RUN: begin
                    if (take) begin
                        st       <= ST_SAVE;
                        step     <= '0;
                        src      <= gnt_src;
                        saved_cc <= cc_cur;
                        info_q   <= io_info;
                    end
                end
                ST_SAVE: begin
                    if (last) begin
                        st      <= ST_INTR;
                        cc_load <= 1'b1;
                        cc_val  <= '0;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                ST_INTR: begin
                    if (ret_cmd) begin
                        st      <= ST_RUN;
                        cc_load <= 1'b1;
                        cc_val  <= saved_cc;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    // R5: the status byte write directly follows the identity write
    a_r5_io_order: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(STAT_LOC)) |->
            ($past(wr_en) && $past(wr_addr) == ADDR_W'(ID_LOC)));
    // R6: leaving the save sequence loads a zero condition code
    a_r6_cc_cleared: assert property (@(posedge clk) disable iff (rst)
        (busy && last) |=> (intr_mode && cc_load && cc_val == '0));
    // R7: interrupt state is held until a return strobe
    a_r7_hold_intr: assert property (@(posedge clk) disable iff (rst)
        (intr_mode && !ret_cmd) |=> (intr_mode && !wr_en));
    // R8: return restores the saved condition code
    a_r8_restore: assert property (@(posedge clk) disable iff (rst)
        (intr_mode && ret_cmd) |=>
            (!intr_mode && cc_load && cc_val == $past(saved_cc)));

endmodule

// File: rtl/int_seq_top.sv
module int_seq_top
    import int_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int TRUNK_W  = 3,
    parameter int DEV_W    = 4,
    parameter int CC_W     = 2,
    parameter int CC_LOC   = 43,
    parameter int ID_LOC   = 47,
    parameter int STAT_LOC = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_trap,
    input  logic               io_done,
    input  logic [TRUNK_W-1:0] io_trunk,
    input  logic [DEV_W-1:0]   io_dev,
    input  logic [7:0]         io_status,
    input  logic               timer_ovf,
    input  logic               arith_exc,
    input  logic [7:0]         mask_byte,
    input  logic [CC_W-1:0]    cc_cur,
    input  logic               ret_cmd,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [7:0]         wr_data,
    output logic               busy,
    output logic               intr_mode,
    output logic [1:0]         cause,
    output logic               cc_load,
    output logic [CC_W-1:0]    cc_val
);
    logic [NSRC-1:0] req, clr, pend, gnt_vec;
    logic            gnt_valid, open, take;
    src_e            gnt_src, cause_e;
    io_info_s        io_info;

    assign req[SRC_TRAP]  = op_trap;
    assign req[SRC_IO]    = io_done;
    assign req[SRC_TIMER] = timer_ovf;
    assign req[SRC_ARITH] = arith_exc;
    assign clr            = take ? gnt_vec : '0;
    assign cause          = cause_e;

    int_pend #(.TRUNK_W(TRUNK_W), .DEV_W(DEV_W)) u_pend (
        .clk(clk), .rst(rst), .req(req), .clr(clr),
        .io_trunk(io_trunk), .io_dev(io_dev), .io_status(io_status),
        .pend(pend), .io_info(io_info)
    );

    int_arb u_arb (
        .clk(clk), .rst(rst), .pend(pend), .mask_byte(mask_byte),
        .open(open), .gnt_valid(gnt_valid), .gnt_src(gnt_src),
        .gnt_vec(gnt_vec)
    );

    int_fsm #(
        .ADDR_W(ADDR_W), .CC_W(CC_W), .CC_LOC(CC_LOC),
        .ID_LOC(ID_LOC), .STAT_LOC(STAT_LOC)
    ) u_fsm (
        .clk(clk), .rst(rst), .gnt_valid(gnt_valid), .gnt_src(gnt_src),
        .io_info(io_info), .cc_cur(cc_cur), .ret_cmd(ret_cmd),
        .open(open), .take(take), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .intr_mode(intr_mode),
        .cause(cause_e), .cc_load(cc_load), .cc_val(cc_val)
    );

    // R1: nothing is written outside the save sequence
    a_r1_write_gated: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !intr_mode);

endmodule

// File: tb/test_int_seq_top.sv
module test_int_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_trap = 0, io_done = 0, timer_ovf = 0, arith_exc = 0;
    logic [2:0] io_trunk = '0;
    logic [3:0] io_dev = '0;
    logic [7:0] io_status = '0;
    logic [7:0] mask_byte = '0;
    logic [1:0] cc_cur = '0;
    logic       ret_cmd = 0;
    logic       wr_en, busy, intr_mode, cc_load;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  cause, cc_val;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    int_seq_top i_int_seq_top (
        .clk(clk), .rst(rst), .op_trap(op_trap), .io_done(io_done),
        .io_trunk(io_trunk), .io_dev(io_dev), .io_status(io_status),
        .timer_ovf(timer_ovf), .arith_exc(arith_exc), .mask_byte(mask_byte),
        .cc_cur(cc_cur), .ret_cmd(ret_cmd), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .intr_mode(intr_mode), .cause(cause),
        .cc_load(cc_load), .cc_val(cc_val)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected winner: trap, then I/O (mask bit 0), timer (bit 1), arith (bit 2)
    function automatic int pick(bit [3:0] r, bit [7:0] mk);
        if (r[0]) return 0;
        if (r[1] && mk[0]) return 1;
        if (r[2] && mk[1]) return 2;
        if (r[3] && mk[2]) return 3;
        return -1;
    endfunction

    // Called at a negedge where the next edge takes source w.
    task automatic service(int w, int cc, int tk, int dv, int st);
        @(negedge clk);
        chk("R5 busy on first save", busy, 1);
        chk("R5 first write enable", wr_en, 1);
        chk("R5 cc address", wr_addr, 43);
        chk("R5 cc data", wr_data, cc);
        if (w == 1) begin
            @(negedge clk);
            chk("R5 id address", wr_addr, 47);
            chk("R5 id data", wr_data, tk * 16 + dv);
            @(negedge clk);
            chk("R5 status address", wr_addr, 48);
            chk("R5 status data", wr_data, st);
        end
        @(negedge clk);
        chk("R6 busy low", busy, 0);
        chk("R6 no write", wr_en, 0);
        chk("R6 intr_mode", intr_mode, 1);
        chk("R6 cc_load", cc_load, 1);
        chk("R6 cc_val zero", cc_val, 0);
        chk("R3 cause", cause, w);
        @(negedge clk);
        chk("R7 stays in interrupt", intr_mode, 1);
        chk("R7 no new take", busy, 0);
        chk("R6 cc_load one cycle", cc_load, 0);
        ret_cmd   = 1'b1;
        mask_byte = 8'h07;
        @(negedge clk);
        ret_cmd = 1'b0;
        chk("R8 left interrupt", intr_mode, 0);
        chk("R8 cc_load on return", cc_load, 1);
        chk("R8 restored cc", cc_val, cc);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 intr_mode", intr_mode, 0);
        chk("R1 cc_load", cc_load, 0);
        mask_byte = 8'h07;
        @(negedge clk);
        chk("R1 nothing pending", busy, 0);

        // R8: return strobe outside interrupt state has no effect
        ret_cmd = 1'b1;
        @(negedge clk);
        ret_cmd = 1'b0;
        chk("R8 idle return no load", cc_load, 0);
        chk("R8 idle return stays", intr_mode, 0);

        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 16; s++) begin
                bit [3:0] rem;
                int cc, tk, dv, st, w;
                cc = (m + s) % 4;
                tk = s % 8;
                dv = (m * 3 + s) % 16;
                st = ((m * 16 + s) ^ 8'hA5) & 8'hFF;
                rem = 4'(s);
                mask_byte = 8'(m);
                cc_cur    = 2'(cc);
                io_trunk  = 3'(tk);
                io_dev    = 4'(dv);
                io_status = 8'(st);
                op_trap   = rem[0];
                io_done   = rem[1];
                timer_ovf = rem[2];
                arith_exc = rem[3];
                @(negedge clk);
                op_trap = 0; io_done = 0; timer_ovf = 0; arith_exc = 0;
                chk("R2 not taken on arrival", busy, 0);
                w = pick(rem, 8'(m));
                if (w < 0) begin
                    @(negedge clk);
                    chk("R4 masked request not taken", busy, 0);
                    mask_byte = 8'h07;
                end
                while ((w = pick(rem, mask_byte)) >= 0) begin
                    service(w, cc, tk, dv, st);
                    rem[w] = 1'b0;
                end
                @(negedge clk);
                chk("R2 pending drained", busy, 0);
                chk("R8 processing resumed", intr_mode, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule